// File: doc/BRIEF.md
# Programmable horizontal sync pulse generator

This block watches a byte-wide 4:2:2 digital video stream and produces a horizontal sync pulse. The stream carries one byte per line-locked clock, interleaved as Cb, Y, Cr, Y, with 1440 active samples on each line. The block looks for the end-of-active-video timing reference and runs a line position counter from it. The counter returns to zero on the byte that follows that reference.

The leading and trailing edges of the pulse are placed at two programmable 11-bit positions on the counter, counted in clock cycles. An inversion bit selects an active-low output. The counter wraps at the line length of the selected standard: 1716 cycles for the 525-line standard and 1728 cycles for the 625-line standard. Because of the wrap, a pulse can start near the end of one line and finish after the next timing reference. Adding N to both positions moves the pulse N cycles later. Adding (line total − N) to both moves it N cycles earlier.

All configuration inputs are taken into an internal shadow only when the counter returns to zero. A setting changed mid-line therefore takes effect cleanly at the next line.

Top module: `hsync_gen`

## Requirements
- R1: In the first cycle after a synchronous active-low reset, `hs_out` is 0. The shadow configuration resets to begin position 2, end position 0, active-high output and the 525-line standard, whatever the configuration inputs are. It keeps these values until the first counter reset point.
- R2: The end-of-active reference is the byte sequence 0xFF, 0x00, 0x00, XY with bit 4 of XY equal to 1. When XY is sampled, the counter becomes 0, so the byte after XY is at position 0. The block then counts as locked.
- R3: The same three-byte preamble followed by an XY byte with bit 4 equal to 0 is a start-of-active reference. It leaves the counter running undisturbed.
- R4: With no reference detected, the counter advances by one each clock. It wraps to 0 after position 1715 when `std_pal`=0, and after position 1727 when `std_pal`=1.
- R5: Once locked, the internal pulse turns active on the cycle the counter equals the begin position. It turns inactive on the cycle the counter equals the end position. It is therefore active for positions begin through end−1.
- R6: When the begin position is greater than the end position, the pulse spans the wrap. It is active from begin to the end of the line, and then from 0 to end−1.
- R7: When the begin position equals the end position, no pulse is produced.
- R8: With the shadow inversion bit at 1, `hs_out` is the complement of the internal pulse (active low). With it at 0, `hs_out` is active high.
- R9: Before the first end-of-active reference after reset, the counter runs freely, and the internal pulse stays inactive.
- R10: The begin, end, inversion and standard inputs are copied into the shadow only at a counter reset point, whether that is a detected reference or a wrap. Changes made mid-line have no effect until the next such point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked pixel byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_byte | input | 8 | Multiplexed 4:2:2 video byte stream |
| std_pal | input | 1 | Line length select: 0 = 1716, 1 = 1728 cycles |
| cfg_begin | input | 11 | Pulse leading-edge position |
| cfg_end | input | 11 | Pulse trailing-edge position |
| cfg_invert | input | 1 | 1 = active-low output |
| hs_out | output | 1 | Horizontal sync output |

## Verification
A counter that is off by k positions shows at the port as both pulse edges shifted by k cycles on the very next line. It also shows as a wrong pulse length at any wrap, because the counter wraps at the wrong place. A missed or false reference detection shows within one line, either as a pulse that never appears or as one that jumps. A shadow captured at the wrong moment shows as an edge inside the line where the configuration was changed, rather than one line later. The bench compares `hs_out` against a cycle-by-cycle reference model built from the requirements, and also counts active cycles per line.

// File: rtl/hsg_pkg.sv
// Package: shared widths, reference-code constants and the shadow
// configuration record for the horizontal sync generator.
package hsg_pkg;

    localparam int POS_W  = 11;   // position field width
    localparam int BYTE_W = 8;    // video byte width
    localparam int HBIT   = 4;    // H flag position inside the XY byte
    localparam int PRE_N  = 3;    // preamble length before XY

    typedef struct packed {
        logic [POS_W-1:0] lead_pos;
        logic [POS_W-1:0] trail_pos;
        logic             inv;
        logic             long_line;
    } hsg_cfg_t;

endpackage

// File: rtl/hsg_trs_detect.sv
// Timing-reference detector.
// Keeps the last PRE_N bytes and flags the cycle in which the current byte
// completes an all-ones / all-zeros / all-zeros preamble with the H flag set.
// Assumes one byte per clock and no byte gaps.
module hsg_trs_detect
    import hsg_pkg::*;
#(
    parameter int DW   = BYTE_W,
    parameter int HPOS = HBIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pix_byte,
    output logic          eav_hit
);

    logic [DW-1:0] hist_q [PRE_N];   // [0] newest, [PRE_N-1] oldest
    logic          pre_ok;

    // Shift the byte history by one stage per clock.
    genvar gi;
    generate
        for (gi = 0; gi < PRE_N; gi++) begin : g_hist
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hist_q[gi] <= '0;
                else if (gi == 0)
                    hist_q[gi] <= pix_byte;
                else
                    hist_q[gi] <= hist_q[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    // Match the preamble and qualify it with the H flag of the XY byte.
    always_comb begin
        pre_ok = (hist_q[PRE_N-1] == {DW{1'b1}});
        for (int k = 0; k < PRE_N-1; k++)
            pre_ok = pre_ok && (hist_q[k] == '0);
        eav_hit = pre_ok && pix_byte[HPOS];
    end

endmodule

// File: rtl/hsg_cfg_shadow.sv
// Configuration shadow.
// Holds the begin/end/inversion/standard settings in force for the current
// line and copies the live inputs only when 'load' is high, which is the
// counter reset point. Also exposes the value the shadow will hold next.
module hsg_cfg_shadow
    import hsg_pkg::*;
#(
    parameter int LEAD_RST  = 2,
    parameter int TRAIL_RST = 0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  hsg_cfg_t cfg_in,
    output hsg_cfg_t sh_q,
    output hsg_cfg_t sh_next
);

    // Select the next shadow value.
    always_comb sh_next = load ? cfg_in : sh_q;

    // Register the shadow with its reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q.lead_pos  <= POS_W'(LEAD_RST);
            sh_q.trail_pos <= POS_W'(TRAIL_RST);
            sh_q.inv       <= 1'b0;
            sh_q.long_line <= 1'b0;
        end else begin
            sh_q <= sh_next;
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sh_q)) else $error("shadow moved outside load"); // R10

endmodule

// File: rtl/hsg_line_counter.sv
// Line position counter.
// Clears on a detected end-of-active reference, otherwise counts up and
// wraps at the shadowed line length. Produces the load strobe for the
// configuration shadow and a lock flag that sets on the first reference.
module hsg_line_counter
    import hsg_pkg::*;
#(
    parameter int SHORT_TOTAL = 1716,
    parameter int LONG_TOTAL  = 1728
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eav_hit,
    input  logic             long_line,
    output logic [POS_W-1:0] cnt_q,
    output logic [POS_W-1:0] cnt_next,
    output logic             load,
    output logic             locked_q,
    output logic             lock_next
);

    localparam logic [POS_W-1:0] SHORT_LAST = POS_W'(SHORT_TOTAL - 1);
    localparam logic [POS_W-1:0] LONG_LAST  = POS_W'(LONG_TOTAL - 1);

    logic [POS_W-1:0] line_last;
    logic             wrap;

    // Compute the next position and the reset-point strobe.
    always_comb begin
        line_last = long_line ? LONG_LAST : SHORT_LAST;
        wrap      = (cnt_q == line_last);
        load      = eav_hit || wrap;
        cnt_next  = load ? '0 : cnt_q + 1'b1;
        lock_next = locked_q || eav_hit;
    end

    // Register the position and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            cnt_q    <= cnt_next;
            locked_q <= lock_next;
        end
    end

    AST_EAV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        eav_hit |=> (cnt_q == '0) && locked_q) else $error("no clear on reference"); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= line_last) else $error("counter past line end"); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == line_last) |=> (cnt_q == '0)) else $error("missed wrap"); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!eav_hit && cnt_q != line_last) |=> (cnt_q == $past(cnt_q) + 1'b1))
        else $error("counter skipped"); // R3

endmodule

// File: rtl/hsg_pulse_shaper.sv
// Pulse shaper.
// Sets the internal pulse when the next counter value reaches the lead
// position and clears it at the trail position, using the configuration
// that will be in force after this edge. Equal positions or no lock force
// the pulse off. The output register applies the polarity.
module hsg_pulse_shaper
    import hsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] cnt_q,
    input  logic [POS_W-1:0] cnt_next,
    input  logic             locked_q,
    input  logic             lock_next,
    input  hsg_cfg_t         sh_q,
    input  hsg_cfg_t         sh_next,
    output logic             hs_out
);

    logic act_q;
    logic act_next;

    // Decide the pulse state for the coming cycle.
    always_comb begin
        if (!lock_next || (sh_next.lead_pos == sh_next.trail_pos))
            act_next = 1'b0;
        else if (cnt_next == sh_next.lead_pos)
            act_next = 1'b1;
        else if (cnt_next == sh_next.trail_pos)
            act_next = 1'b0;
        else
            act_next = act_q;
    end

    // Register the pulse and the polarity-corrected output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            hs_out <= 1'b0;
        end else begin
            act_q  <= act_next;
            hs_out <= act_next ^ sh_next.inv;
        end
    end

    AST_PRELOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_q |-> !act_q) else $error("pulse before lock"); // R9
    AST_EQUAL_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.lead_pos == sh_q.trail_pos) |-> !act_q) else $error("pulse with equal edges"); // R7
    AST_RISE_AT_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> (cnt_q == sh_q.lead_pos)) else $error("rise off position"); // R5
    AST_FALL_AT_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(act_q) && (sh_q.lead_pos != sh_q.trail_pos)) |-> (cnt_q == sh_q.trail_pos))
        else $error("fall off position"); // R5
    AST_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        hs_out == (act_q ^ sh_q.inv)) else $error("polarity mismatch"); // R8

endmodule

// File: rtl/hsync_gen.sv
// Horizontal sync generator, top level.
// Detects end-of-active references in the byte stream, runs the line
// position counter and shapes a programmable sync pulse from it.
// Assumes a continuous one-byte-per-clock stream on the line-locked clock.
module hsync_gen #(
    parameter int LINE_SHORT = 1716,
    parameter int LINE_LONG  = 1728,
    parameter int BEGIN_RST  = 2,
    parameter int END_RST    = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  pix_byte,
    input  logic        std_pal,
    input  logic [10:0] cfg_begin,
    input  logic [10:0] cfg_end,
    input  logic        cfg_invert,
    output logic        hs_out
);

    import hsg_pkg::*;

    logic             eav_hit;
    logic             load;
    logic             locked_q;
    logic             lock_next;
    logic [POS_W-1:0] cnt_q;
    logic [POS_W-1:0] cnt_next;
    hsg_cfg_t         cfg_live;
    hsg_cfg_t         sh_q;
    hsg_cfg_t         sh_next;

    // Gather the live configuration inputs into one record.
    always_comb begin
        cfg_live.lead_pos  = cfg_begin;
        cfg_live.trail_pos = cfg_end;
        cfg_live.inv       = cfg_invert;
        cfg_live.long_line = std_pal;
    end

    hsg_trs_detect #(.DW(BYTE_W), .HPOS(HBIT)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_byte (pix_byte),
        .eav_hit  (eav_hit)
    );

    hsg_cfg_shadow #(.LEAD_RST(BEGIN_RST), .TRAIL_RST(END_RST)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .cfg_in  (cfg_live),
        .sh_q    (sh_q),
        .sh_next (sh_next)
    );

    hsg_line_counter #(.SHORT_TOTAL(LINE_SHORT), .LONG_TOTAL(LINE_LONG)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .eav_hit   (eav_hit),
        .long_line (sh_q.long_line),
        .cnt_q     (cnt_q),
        .cnt_next  (cnt_next),
        .load      (load),
        .locked_q  (locked_q),
        .lock_next (lock_next)
    );

    hsg_pulse_shaper u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_q     (cnt_q),
        .cnt_next  (cnt_next),
        .locked_q  (locked_q),
        .lock_next (lock_next),
        .sh_q      (sh_q),
        .sh_next   (sh_next),
        .hs_out    (hs_out)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !hs_out) else $error("output active after reset"); // R1

endmodule

// File: tb/hsync_gen_bench.sv
// Directed bench for hsync_gen: one task per scenario, a cycle-accurate
// reference model written from the requirements, and per-line counts.
module hsync_gen_bench;

    localparam time CYC = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pix_byte = 8'h80;
    logic        std_pal = 1'b0;
    logic [10:0] cfg_begin = 11'd0;
    logic [10:0] cfg_end = 11'd0;
    logic        cfg_invert = 1'b0;
    logic        hs_out;

    int checks = 0;
    int failures = 0;

    // reference model state
    int       m_pos;
    bit       m_lock;
    bit [7:0] m_h0, m_h1, m_h2;
    int       m_b, m_e;
    bit       m_inv, m_pal;
    bit       m_act;
    int       mism;
    int       first_bad_pos;
    int       first_bad_act, first_bad_exp;
    int       n_high;
    bit       fill_tog;

    always #(CYC/2) clk = ~clk;

    hsync_gen u_hsync_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_byte   (pix_byte),
        .std_pal    (std_pal),
        .cfg_begin  (cfg_begin),
        .cfg_end    (cfg_end),
        .cfg_invert (cfg_invert),
        .hs_out     (hs_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pos = 0; m_lock = 0; m_h0 = 0; m_h1 = 0; m_h2 = 0;
        m_b = 2; m_e = 0; m_inv = 0; m_pal = 0; m_act = 0;
    endtask

    // Model one clock edge with byte b (R2, R3, R4, R5, R6, R7, R10).
    task automatic model_step(input bit [7:0] b);
        bit eav;
        int last;
        eav  = (m_h2 == 8'hFF) && (m_h1 == 8'h00) && (m_h0 == 8'h00) && b[4];
        last = m_pal ? 1727 : 1715;
        if (eav || m_pos == last) begin
            m_pos = 0;
            m_b = cfg_begin; m_e = cfg_end; m_inv = cfg_invert; m_pal = std_pal;
        end else begin
            m_pos = m_pos + 1;
        end
        if (eav) m_lock = 1;
        m_h2 = m_h1; m_h1 = m_h0; m_h0 = b;
        if (!m_lock || m_b == m_e) m_act = 0;
        else if (m_pos == m_b)     m_act = 1;
        else if (m_pos == m_e)     m_act = 0;
    endtask

    task automatic drive_byte(input bit [7:0] b);
        bit exp;
        pix_byte = b;
        @(posedge clk);
        model_step(b);
        @(negedge clk);
        exp = m_act ^ m_inv;
        if (hs_out === 1'b1) n_high++;
        if (hs_out !== exp) begin
            if (mism == 0) begin
                first_bad_pos = m_pos; first_bad_act = hs_out; first_bad_exp = exp;
            end
            mism++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            fill_tog = ~fill_tog;
            drive_byte(fill_tog ? 8'h10 : 8'h80);
        end
    endtask

    task automatic send_ref(input bit [7:0] xy);
        drive_byte(8'hFF); drive_byte(8'h00); drive_byte(8'h00); drive_byte(xy);
    endtask

    task automatic scen_start();
        mism = 0; n_high = 0;
    endtask

    task automatic scen_model_check(input string req);
        if (mism != 0)
            $display("  first mismatch at position %0d: hs=%0d model=%0d",
                     first_bad_pos, first_bad_act, first_bad_exp);
        check(mism == 0, req, "cycle mismatches against model", mism, 0);
    endtask

    // R1: reset state and shadow defaults regardless of live inputs.
    task automatic t_reset();
        cfg_invert = 1'b1; cfg_begin = 11'd0; cfg_end = 11'd0;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check(hs_out === 1'b0, "R1", "hs_out after reset", hs_out, 0);
        scen_start();
        idle(20);
        check(n_high == 0, "R1", "inversion input ignored before load", n_high, 0);
        cfg_invert = 1'b0;
    endtask

    // R9: no pulse before the first reference, across several wraps.
    task automatic t_prelock();
        cfg_begin = 11'd5; cfg_end = 11'd50; std_pal = 1'b0;
        scen_start();
        idle(2 * 1716);
        check(n_high == 0, "R9", "active cycles before lock", n_high, 0);
        scen_model_check("R9");
    endtask

    // R2 R5 R4: lock on reference, pulse 10..29 on the short line.
    task automatic t_basic();
        cfg_begin = 11'd10; cfg_end = 11'd30; std_pal = 1'b0;
        scen_start();
        send_ref(8'h9D);
        n_high = 0;
        idle(2 * 1716 - 1);
        check(n_high == 40, "R5", "active cycles over two short lines", n_high, 40);
        scen_model_check("R2_R4_R5");
    endtask

    // R3: start-of-active reference mid-line leaves the counter alone.
    task automatic t_sav();
        scen_start();
        idle(100);
        send_ref(8'h80);
        n_high = 0;
        idle(1716);
        check(n_high == 20, "R3", "active cycles in line after SAV", n_high, 20);
        scen_model_check("R3");
    endtask

    // R6 R4: long line with a pulse straddling the wrap.
    task automatic t_straddle();
        cfg_begin = 11'd1720; cfg_end = 11'd4; std_pal = 1'b1;
        scen_start();
        send_ref(8'h9D);
        idle(2 * 1728);
        n_high = 0;
        idle(1728);
        check(n_high == 12, "R6", "active cycles per long line", n_high, 12);
        scen_model_check("R4_R6");
    endtask

    // R7: equal edges give no pulse.
    task automatic t_equal();
        cfg_begin = 11'd100; cfg_end = 11'd100; std_pal = 1'b0;
        scen_start();
        send_ref(8'h9D);
        idle(1716);
        n_high = 0;
        idle(1716);
        check(n_high == 0, "R7", "active cycles with equal edges", n_high, 0);
        scen_model_check("R7");
    endtask

    // R8: inverted polarity.
    task automatic t_invert();
        cfg_begin = 11'd10; cfg_end = 11'd30; cfg_invert = 1'b1;
        scen_start();
        send_ref(8'h9D);
        idle(1716);
        n_high = 0;
        idle(1716);
        check(n_high == 1696, "R8", "high cycles per line when inverted", n_high, 1696);
        scen_model_check("R8");
        cfg_invert = 1'b0;
    endtask

    // R10: mid-line change waits for the next reset point.
    task automatic t_midline();
        cfg_begin = 11'd10; cfg_end = 11'd30; cfg_invert = 1'b0;
        scen_start();
        send_ref(8'h9D);
        idle(1716);
        send_ref(8'h9D);
        idle(500);
        cfg_begin = 11'd600; cfg_end = 11'd700;
        n_high = 0;
        idle(1215);
        check(n_high == 0, "R10", "active cycles after mid-line change", n_high, 0);
        n_high = 0;
        idle(1716);
        check(n_high == 100, "R10", "active cycles on following line", n_high, 100);
        scen_model_check("R10");
    endtask

    initial begin
        #(CYC * 150000);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        fill_tog = 1'b0;
        model_reset();
        t_reset();
        t_prelock();
        t_basic();
        t_sav();
        t_straddle();
        t_equal();
        t_invert();
        t_midline();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule